// File: doc/BRIEF.md
# Hours-Minutes-Seconds Clock with Repeating Interval Alarm

This block keeps wall time as three byte-wide counters (seconds, minutes, hours) that advance on a single-cycle one-per-second strobe supplied by the surrounding chip. The hours counter either wraps at the end of a day or runs freely through the whole byte range. Every hours wrap latches a sticky midnight flag. A separate 8-bit interval counter counts events of a selectable timebase and latches an alarm flag each time it reaches a programmed value. It then restarts, so the alarm repeats.

Software reaches everything through a byte-wide register port with a combinational read path. Two reset inputs are provided. The power-on reset clears everything. The system reset clears control, flags and the interval counter, but the time of day keeps running through it. The interrupt output combines the two flags, each gated by its own enable bit.

Top module: `rtc_core`

## Requirements
- R1: After power-on reset, every register at addresses 0 to 6 reads 0 and `irq` is low.
- R2: Each cycle with `tickSec` high advances seconds by one. At 59 or above, seconds return to 0 and minutes advance by one. At 59 or above, minutes return to 0 on that carry.
- R3: A minutes carry advances the hours counter by one.
- R4: With control bit 0 set (day mode), a carry into hours at 23 or above sets hours to 0 and sets status bit 0 (midnight).
- R5: With control bit 0 clear, hours count up to 255 and wrap to 0. Only that wrap sets status bit 0. Passing 23 to 24 sets nothing.
- R6: The status flags (bit 0 midnight, bit 1 alarm) are sticky and clear only when 1 is written to the bit. A written 0 leaves them set.
- R7: While `sysRstN` is low, seconds, minutes and hours keep their values and writes are ignored. Control, status and the interval count read 0 after it. Only `porRstN` clears the time.
- R8: With control bit 1 set (interval enable), the interval counter (read at address 6) counts timebase events. On the event that would make it equal to the interval value (address 5), status bit 1 is set and the counter restarts at 0, so alarms repeat.
- R9: Control bits 3:2 select the timebase: 00 counts `tick128`, 01 counts seconds, 10 counts minutes carries, 11 counts hours carries. Events of any other kind leave the counter unchanged.
- R10: `irq` equals (midnight AND control bit 4) OR (alarm AND control bit 5).
- R11: A write to seconds, minutes or hours in the same cycle as a tick loads the written value into that field. The carry the tick would have put into that field is lost. The other fields advance as the tick dictates from their old values.
- R12: With interval enable clear, the interval counter holds 0 and no alarm is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous, clears everything |
| sysRstN | input | 1 | System reset, active low, synchronous, spares the time |
| tickSec | input | 1 | One-cycle strobe once per second |
| tick128 | input | 1 | One-cycle strobe 128 times per second |
| wrEn | input | 1 | Register write enable |
| addr | input | 3 | Register address: 0 control, 1 status, 2 sec, 3 min, 4 hour, 5 interval value, 6 interval count |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the rare carries: an hours wrap in free mode needs 256 hours, and an interval alarm on the hours timebase needs whole hours of ticks. The bench loads the time counters with values just below a carry and then ticks once. Collisions between a tick and a write are forced by raising the strobe and the write enable in the same cycle. The seconds and minutes are checked over a full hour against arithmetic on a running tick count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int ADR_W  = 3;

  localparam logic [ADR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] ADR_STAT = 3'd1;
  localparam logic [ADR_W-1:0] ADR_SEC  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_MIN  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_HOUR = 3'd4;
  localparam logic [ADR_W-1:0] ADR_INTV = 3'd5;
  localparam logic [ADR_W-1:0] ADR_ICNT = 3'd6;

  // control register bit positions
  localparam int CB_DAY   = 0;
  localparam int CB_IEN   = 1;
  localparam int CB_TB_LO = 2;
  localparam int CB_MIE   = 4;
  localparam int CB_AIE   = 5;
  localparam int CTRL_W   = 6;

  typedef enum logic [1:0] {
    TB_FAST = 2'b00,
    TB_SEC  = 2'b01,
    TB_MIN  = 2'b10,
    TB_HOUR = 2'b11
  } timeBase_e;

  typedef struct packed {
    logic             wrSec;
    logic             wrMin;
    logic             wrHour;
    logic [REG_W-1:0] wrVal;
    logic             dayMode;
    logic             intvEn;
    timeBase_e        tbSel;
    logic [REG_W-1:0] intvVal;
  } rtcCmd_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wrData,
  input  logic             midEvt,
  input  logic             almEvt,
  output rtcCmd_t          cmd,
  output logic [REG_W-1:0] ctrlQ,
  output logic             midFlag,
  output logic             almFlag,
  output logic [REG_W-1:0] intvQ,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrlBits;
  logic              wrOk;
  logic              clrMid;
  logic              clrAlm;

  assign wrOk   = wrEn && sysRstN;
  assign clrMid = wrOk && (addr == ADR_STAT) && wrData[0];
  assign clrAlm = wrOk && (addr == ADR_STAT) && wrData[1];

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN) begin
      ctrlBits <= '0;
      intvQ    <= '0;
      midFlag  <= 1'b0;
      almFlag  <= 1'b0;
    end else begin
      if (wrOk && addr == ADR_CTRL) ctrlBits <= wrData[CTRL_W-1:0];
      if (wrOk && addr == ADR_INTV) intvQ    <= wrData;
      midFlag <= midEvt || (midFlag && !clrMid);
      almFlag <= almEvt || (almFlag && !clrAlm);
    end
  end

  assign ctrlQ = {{(REG_W-CTRL_W){1'b0}}, ctrlBits};

  always_comb begin
    cmd.wrSec   = wrOk && (addr == ADR_SEC);
    cmd.wrMin   = wrOk && (addr == ADR_MIN);
    cmd.wrHour  = wrOk && (addr == ADR_HOUR);
    cmd.wrVal   = wrData;
    cmd.dayMode = ctrlBits[CB_DAY];
    cmd.intvEn  = ctrlBits[CB_IEN];
    cmd.tbSel   = timeBase_e'(ctrlBits[CB_TB_LO +: 2]);
    cmd.intvVal = intvQ;
  end

  assign irq = (midFlag && ctrlBits[CB_MIE]) || (almFlag && ctrlBits[CB_AIE]);
endmodule

// File: rtl/rtc_dp.sv
module rtc_dp
  import rtc_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int MIN_LAST  = 59,
  parameter int DAY_LAST  = 23
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             tickSec,
  input  logic             tick128,
  input  rtcCmd_t          cmd,
  output logic [REG_W-1:0] secQ,
  output logic [REG_W-1:0] minQ,
  output logic [REG_W-1:0] hourQ,
  output logic [REG_W-1:0] icntQ,
  output logic             midEvt,
  output logic             almEvt
);
  localparam logic [REG_W-1:0] SEC_END  = REG_W'(SEC_LAST);
  localparam logic [REG_W-1:0] MIN_END  = REG_W'(MIN_LAST);
  localparam logic [REG_W-1:0] DAY_END  = REG_W'(DAY_LAST);
  localparam logic [REG_W-1:0] FREE_END = {REG_W{1'b1}};

  logic secEnd, minEnd, hourEnd;
  logic minStep, hourStep;
  logic tbEvt;
  logic [REG_W-1:0] icntNext;

  assign secEnd   = secQ >= SEC_END;
  assign minEnd   = minQ >= MIN_END;
  assign hourEnd  = cmd.dayMode ? (hourQ >= DAY_END) : (hourQ == FREE_END);
  assign minStep  = tickSec && secEnd;
  assign hourStep = minStep && minEnd;
  assign midEvt   = hourStep && hourEnd && !cmd.wrHour;

  // time of day: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
    end else begin
      if (cmd.wrSec)      secQ  <= cmd.wrVal;
      else if (tickSec)   secQ  <= secEnd ? '0 : secQ + 1'b1;
      if (cmd.wrMin)      minQ  <= cmd.wrVal;
      else if (minStep)   minQ  <= minEnd ? '0 : minQ + 1'b1;
      if (cmd.wrHour)     hourQ <= cmd.wrVal;
      else if (hourStep)  hourQ <= hourEnd ? '0 : hourQ + 1'b1;
    end
  end

  always_comb begin
    unique case (cmd.tbSel)
      TB_FAST: tbEvt = tick128;
      TB_SEC:  tbEvt = tickSec;
      TB_MIN:  tbEvt = minStep;
      TB_HOUR: tbEvt = hourStep;
      default: tbEvt = 1'b0;
    endcase
  end

  assign icntNext = icntQ + 1'b1;
  assign almEvt   = cmd.intvEn && tbEvt && (icntNext == cmd.intvVal);

  always_ff @(posedge clk) begin
    if (!porRstN || !sysRstN)  icntQ <= '0;
    else if (!cmd.intvEn)      icntQ <= '0;
    else if (tbEvt)            icntQ <= almEvt ? '0 : icntNext;
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int DAY_LAST = 23
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             tickSec,
  input  logic             tick128,
  input  logic             wrEn,
  input  logic [ADR_W-1:0] addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);
  rtcCmd_t          cmd;
  logic [REG_W-1:0] ctrlQ, intvQ, secQ, minQ, hourQ, icntQ;
  logic             midFlag, almFlag, midEvt, almEvt;

  rtc_ctrl u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .midEvt(midEvt), .almEvt(almEvt),
    .cmd(cmd), .ctrlQ(ctrlQ), .midFlag(midFlag), .almFlag(almFlag),
    .intvQ(intvQ), .irq(irq)
  );

  rtc_dp #(.SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .DAY_LAST(DAY_LAST)) u_dp (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .tickSec(tickSec), .tick128(tick128), .cmd(cmd),
    .secQ(secQ), .minQ(minQ), .hourQ(hourQ), .icntQ(icntQ),
    .midEvt(midEvt), .almEvt(almEvt)
  );

  always_comb begin
    unique case (addr)
      ADR_CTRL: rdData = ctrlQ;
      ADR_STAT: rdData = {{(REG_W-2){1'b0}}, almFlag, midFlag};
      ADR_SEC:  rdData = secQ;
      ADR_MIN:  rdData = minQ;
      ADR_HOUR: rdData = hourQ;
      ADR_INTV: rdData = intvQ;
      ADR_ICNT: rdData = icntQ;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int SEC_LAST = 59,
  parameter int MIN_LAST = 59,
  parameter int DAY_LAST = 23
) (
  input logic       clk,
  input logic       porRstN,
  input logic       sysRstN,
  input logic       tickSec,
  input logic       wrEn,
  input logic [2:0] addr,
  input logic       irq,
  input logic [7:0] ctrlQ,
  input logic       midFlag,
  input logic [7:0] secQ,
  input logic [7:0] minQ,
  input logic [7:0] hourQ,
  input logic [7:0] icntQ
);
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!porRstN)
    tickSec && !wrEn && secQ < 8'(SEC_LAST) |=> secQ == $past(secQ) + 8'd1); // R2
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!porRstN)
    tickSec && !wrEn && secQ >= 8'(SEC_LAST) |=> secQ == 8'd0); // R2
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    !tickSec && !wrEn |=> $stable(secQ) && $stable(minQ) && $stable(hourQ)); // R7
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    ctrlQ[0] && tickSec && !wrEn && secQ >= 8'(SEC_LAST) && minQ >= 8'(MIN_LAST)
    && hourQ >= 8'(DAY_LAST) |=> hourQ == 8'd0 && midFlag); // R4
  AST_MID_STICKY: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    midFlag && !(wrEn && addr == 3'd1) |=> midFlag); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !ctrlQ[4] && !ctrlQ[5] |-> !irq); // R10
  AST_INTV_IDLE: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    !ctrlQ[1] |=> icntQ == 8'd0); // R12
endmodule

bind rtc_core rtc_core_chk #(.SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .DAY_LAST(DAY_LAST)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickSec(tickSec),
  .wrEn(wrEn), .addr(addr), .irq(irq), .ctrlQ(ctrlQ), .midFlag(midFlag),
  .secQ(secQ), .minQ(minQ), .hourQ(hourQ), .icntQ(icntQ)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       porRstN, sysRstN, tickSec, tick128, wrEn;
  logic [2:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       irq;
  int         nRun = 0;
  int         nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_core u0 (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .tickSec(tickSec),
    .tick128(tick128), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input int exp);
    addr = a;
    #1;
    check(req, int'(rdData), exp);
  endtask

  task automatic irqChk(input string req, input int exp);
    #1;
    check(req, int'(irq), exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickSec = 1'b1;
      @(negedge clk); tickSec = 1'b0;
    end
  endtask

  task automatic fast(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick128 = 1'b1;
      @(negedge clk); tick128 = 1'b0;
    end
  endtask

  task automatic setTime(input int h, input int m, input int s);
    wr(3'd4, 8'(h)); wr(3'd3, 8'(m)); wr(3'd2, 8'(s));
  endtask

  task automatic collide(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tickSec = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    tickSec = 1'b0; wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    porRstN = 1'b0; sysRstN = 1'b0; tickSec = 1'b0; tick128 = 1'b0;
    wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    porRstN = 1'b1; sysRstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) rdChk("R1", 3'(a), 0);
    irqChk("R1", 0);

    // R2 / R3 full-hour sweep of seconds and minutes
    for (int t = 1; t <= 3600; t++) begin
      ticks(1);
      rdChk("R2 sec", 3'd2, t % 60);
      rdChk("R2 min", 3'd3, (t / 60) % 60);
      if (t % 60 == 0) rdChk("R3 hour", 3'd4, t / 3600);
    end
    rdChk("R3 hour after 3600", 3'd4, 1);

    // R4 day-mode wrap
    wr(3'd0, 8'h01);
    setTime(23, 59, 59);
    ticks(1);
    rdChk("R4 sec", 3'd2, 0); rdChk("R4 min", 3'd3, 0); rdChk("R4 hour", 3'd4, 0);
    rdChk("R4 midnight", 3'd1, 1);

    // R6 write-one-to-clear
    wr(3'd1, 8'h00); rdChk("R6 zero write keeps", 3'd1, 1);
    wr(3'd1, 8'h01); rdChk("R6 one write clears", 3'd1, 0);

    // R5 free-running hours
    wr(3'd0, 8'h00);
    setTime(23, 59, 59); ticks(1);
    rdChk("R5 hour 24", 3'd4, 24); rdChk("R5 no flag at 24", 3'd1, 0);
    setTime(255, 59, 59); ticks(1);
    rdChk("R5 hour wrap", 3'd4, 0); rdChk("R5 flag at wrap", 3'd1, 1);

    // R10 interrupt gating
    irqChk("R10 masked", 0);
    wr(3'd0, 8'h10); irqChk("R10 midnight enabled", 1);
    wr(3'd0, 8'h20); irqChk("R10 wrong enable", 0);
    wr(3'd0, 8'h10); wr(3'd1, 8'h01); irqChk("R10 cleared", 0);

    // R11 write/tick collisions
    wr(3'd0, 8'h00);
    setTime(5, 10, 59); collide(3'd2, 8'd30);
    rdChk("R11 sec written", 3'd2, 30); rdChk("R11 min carried", 3'd3, 11);
    setTime(5, 10, 59); collide(3'd3, 8'd40);
    rdChk("R11 min written", 3'd3, 40); rdChk("R11 sec wrapped", 3'd2, 0);
    rdChk("R11 hour kept", 3'd4, 5);
    setTime(5, 59, 59); collide(3'd4, 8'd9);
    rdChk("R11 hour written", 3'd4, 9); rdChk("R11 min wrapped", 3'd3, 0);

    // R8 interval on seconds, repeating
    wr(3'd5, 8'd5); wr(3'd0, 8'h26);
    ticks(4);
    rdChk("R8 count 4", 3'd6, 4); rdChk("R8 no alarm yet", 3'd1, 0); irqChk("R8 irq low", 0);
    ticks(1);
    rdChk("R8 alarm", 3'd1, 2); rdChk("R8 restart", 3'd6, 0); irqChk("R8 irq", 1);
    wr(3'd1, 8'h02);
    ticks(4); rdChk("R8 repeat not yet", 3'd1, 0);
    ticks(1); rdChk("R8 repeat alarm", 3'd1, 2);
    wr(3'd1, 8'h02);

    // R9 fast timebase ignores seconds
    wr(3'd0, 8'h02); wr(3'd5, 8'd3);
    fast(2); ticks(1);
    rdChk("R9 fast count", 3'd6, 2); rdChk("R9 fast no alarm", 3'd1, 0);
    fast(1); rdChk("R9 fast alarm", 3'd1, 2);
    wr(3'd1, 8'h02);

    // R9 minutes timebase
    wr(3'd0, 8'h00); wr(3'd2, 8'd0);
    wr(3'd5, 8'd2); wr(3'd0, 8'h0A);
    fast(3); ticks(60);
    rdChk("R9 min count", 3'd6, 1);
    ticks(59); rdChk("R9 min not yet", 3'd1, 0);
    ticks(1); rdChk("R9 min alarm", 3'd1, 2);
    wr(3'd1, 8'h02);

    // R9 hours timebase
    wr(3'd5, 8'd1); wr(3'd0, 8'h0E);
    setTime(3, 59, 58); ticks(1); rdChk("R9 hour not yet", 3'd1, 0);
    ticks(1); rdChk("R9 hour alarm", 3'd1, 2);
    wr(3'd1, 8'h02);

    // R12 disabled interval
    wr(3'd0, 8'h04); wr(3'd5, 8'd1);
    ticks(3);
    rdChk("R12 count held", 3'd6, 0); rdChk("R12 no alarm", 3'd1, 0);

    // R7 system reset keeps time
    wr(3'd0, 8'h3F); wr(3'd5, 8'd9);
    setTime(7, 8, 9);
    wr(3'd0, 8'h11); wr(3'd4, 8'd255); wr(3'd3, 8'd59); wr(3'd2, 8'd59); ticks(1);
    setTime(7, 8, 9);
    @(negedge clk); sysRstN = 1'b0;
    wrEn = 1'b1; addr = 3'd2; wrData = 8'd55;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk); sysRstN = 1'b1;
    rdChk("R7 sec kept", 3'd2, 9); rdChk("R7 min kept", 3'd3, 8); rdChk("R7 hour kept", 3'd4, 7);
    rdChk("R7 ctrl cleared", 3'd0, 0); rdChk("R7 stat cleared", 3'd1, 0);
    rdChk("R7 intv cleared", 3'd5, 0);
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    rdChk("R7 por sec", 3'd2, 0); rdChk("R7 por hour", 3'd4, 0);

    finishRun();
  end
endmodule